// File: doc/BRIEF.md
# Three-Wire Synthesizer Register Loader

This block takes 20-bit configuration words from a three-wire serial port (data, serial clock, latch enable) and places them into the two control registers of a frequency synthesizer. The serial pins are asynchronous. They are synchronized into a fast system clock, and every edge is detected there. Bits are shifted in most significant bit first, one on each rising serial clock. The last bit shifted in is a routing bit. It selects either the main divider register, which holds the swallow count, the program count and a mode field, or the reference register, which holds the reference ratio and a flag field.

The shifted word has no effect until the latch enable rises. On that edge the word is copied into the selected register, and a one-cycle update strobe for that register is raised. If the number of serial clocks is not exactly 20, the word is discarded and a one-cycle frame error is raised instead. A timing monitor counts system clock cycles to enforce a minimum time (`MIN_TIME_NS`, default 1 µs) on serial clock high and low width, data setup, data hold, latch-enable spacing after the last clock, and latch-enable width. It reports each kind of violation on its own pulse bit.

A three-state controller sequences each frame. `ST_IDLE` is the state with no bits received. A serial clock rise moves it to `ST_SHIFT`, where bits accumulate. A latch-enable rise in either `ST_IDLE` or `ST_SHIFT` moves it to `ST_LATCH`, where serial clocks are ignored. A latch-enable fall returns it to `ST_IDLE` with the bit count cleared.

Top module: `synth_reg_loader`

## Requirements
- R1: Each rising serial clock outside `ST_LATCH` shifts the data pin into the word register, most significant bit first. The word register is 20 bits with S19 at bit 19 and the routing bit C at bit 0.
- R2: On a latch rise after exactly 20 clocks with C=0, the main register loads: mode = bit 19, program count = bits 18..8, swallow count = bits 7..1.
- R3: On a latch rise after exactly 20 clocks with C=1, the reference register loads: ratio = bits 8..1 (the low `REF_RATIO_BITS` above C) and flags = bits 19..9 (all bits above the ratio).
- R4: Register outputs change only in the cycle of their update strobe. Shifting a full word without a latch rise leaves every output unchanged.
- R5: Every load raises exactly one one-cycle strobe, `main_upd` or `ref_upd`, naming the register that changed. Update strobes and frame error never coincide.
- R6: A latch rise after any clock count other than 20 discards the word, raises `frame_err` for one cycle and updates nothing.
- R7: After reset all register outputs, strobes and fault bits are zero.
- R8: A serial clock high or low phase shorter than the minimum time pulses `timing_fault[0]`.
- R9: A serial clock rise less than the minimum time after a data change pulses `timing_fault[1]` (setup).
- R10: A data change less than the minimum time after a serial clock rise pulses `timing_fault[2]` (hold).
- R11: A latch rise less than the minimum time after the last serial clock rise pulses `timing_fault[3]`.
- R12: A latch-enable high phase shorter than the minimum time pulses `timing_fault[4]`.
- R13: Serial clocks while latch enable is high are ignored. After the latch falls, the next word starts from a bit count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_data | input | 1 | Serial data pin (asynchronous) |
| ser_clk | input | 1 | Serial clock pin (asynchronous) |
| ser_le | input | 1 | Latch-enable pin (asynchronous) |
| main_swallow | output | A_BITS | Swallow count of the main register |
| main_count | output | N_BITS | Program count of the main register |
| main_mode | output | WORD_BITS-1-A_BITS-N_BITS | Mode field of the main register |
| ref_ratio | output | REF_RATIO_BITS | Reference divide ratio |
| ref_flags | output | WORD_BITS-1-REF_RATIO_BITS | Switch/function flags of the reference register |
| main_upd | output | 1 | One-cycle strobe: main register loaded |
| ref_upd | output | 1 | One-cycle strobe: reference register loaded |
| frame_err | output | 1 | One-cycle strobe: word discarded for a wrong bit count |
| timing_fault | output | 5 | One-cycle pulses per violation kind: clock width, setup, hold, latch spacing, latch width |

## Verification
The embedded assertions check, on every cycle, that strobes are mutually exclusive single pulses and that register outputs hold between strobes. They also check that the bit count stays bounded, and that every frame error or fault pulse follows the edge that can cause it. Only the bench scenarios can show that the right fields land in the right register bits, and that short or long frames are discarded. They also show that clocks during the latch are ignored and that each kind of timing violation is reported alone under deliberately shortened intervals, while clean traffic reports none.

// File: rtl/synth_loader_pkg.sv
package synth_loader_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_LATCH = 2'd2
    } load_state_t;

    localparam int FAULT_CLK_WIDTH = 0;
    localparam int FAULT_SETUP     = 1;
    localparam int FAULT_HOLD      = 2;
    localparam int FAULT_LE_SPACE  = 3;
    localparam int FAULT_LE_WIDTH  = 4;
    localparam int NUM_FAULTS      = 5;

    localparam int PIN_DATA = 0;
    localparam int PIN_CLK  = 1;
    localparam int PIN_LE   = 2;
    localparam int NUM_PINS = 3;

endpackage

// File: rtl/loader_pin_sync.sv
module loader_pin_sync #(
    parameter int NUM_PINS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_async,
    output logic [NUM_PINS-1:0] pin_level,
    output logic [NUM_PINS-1:0] pin_rise,
    output logic [NUM_PINS-1:0] pin_fall
);

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pin
        logic meta_q, sync_q, prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pin_async[g];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign pin_level[g] = sync_q;
        assign pin_rise[g]  = sync_q & ~prev_q;
        assign pin_fall[g]  = ~sync_q & prev_q;
    end

endmodule

// File: rtl/loader_timing_mon.sv
module loader_timing_mon
    import synth_loader_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 20,
    parameter int MIN_TIME_NS   = 1000,
    localparam int MIN_CYC = (MIN_TIME_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS,
    localparam int AGE_W   = $clog2(MIN_CYC + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_rise,
    input  logic                  clk_fall,
    input  logic                  data_edge,
    input  logic                  le_rise,
    input  logic                  le_fall,
    output logic [NUM_FAULTS-1:0] fault
);

    localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(MIN_CYC);
    localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(MIN_CYC - 1);

    logic [AGE_W-1:0] clk_age_q, rise_age_q, data_age_q, le_age_q;

    function automatic logic [AGE_W-1:0] age_next(input logic restart,
                                                  input logic [AGE_W-1:0] age);
        if (restart)             return '0;
        else if (age != AGE_SAT) return age + 1'b1;
        else                     return age;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_age_q  <= AGE_SAT;
            rise_age_q <= AGE_SAT;
            data_age_q <= AGE_SAT;
            le_age_q   <= AGE_SAT;
            fault      <= '0;
        end else begin
            fault[FAULT_CLK_WIDTH] <= (clk_rise | clk_fall) && (clk_age_q < AGE_LIM);
            fault[FAULT_SETUP]     <= clk_rise && (data_age_q < AGE_LIM);
            fault[FAULT_HOLD]      <= data_edge && (rise_age_q < AGE_LIM);
            fault[FAULT_LE_SPACE]  <= le_rise && (rise_age_q < AGE_LIM);
            fault[FAULT_LE_WIDTH]  <= le_fall && (le_age_q < AGE_LIM);
            clk_age_q  <= age_next(clk_rise | clk_fall, clk_age_q);
            rise_age_q <= age_next(clk_rise, rise_age_q);
            data_age_q <= age_next(data_edge, data_age_q);
            le_age_q   <= age_next(le_rise, le_age_q);
        end
    end

    assert_clk_fault_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fault[FAULT_CLK_WIDTH] |-> $past(clk_rise | clk_fall));
    assert_setup_fault_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fault[FAULT_SETUP] |-> $past(clk_rise));
    assert_hold_fault_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault[FAULT_HOLD] |-> $past(data_edge));
    assert_space_fault_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fault[FAULT_LE_SPACE] |-> $past(le_rise));
    assert_width_fault_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
        fault[FAULT_LE_WIDTH] |-> $past(le_fall));

endmodule

// File: rtl/loader_frame_fsm.sv
module loader_frame_fsm
    import synth_loader_pkg::*;
#(
    parameter int WORD_BITS      = 20,
    parameter int A_BITS         = 7,
    parameter int N_BITS         = 11,
    parameter int REF_RATIO_BITS = 8,
    localparam int MODE_BITS = WORD_BITS - 1 - A_BITS - N_BITS,
    localparam int FLAG_BITS = WORD_BITS - 1 - REF_RATIO_BITS,
    localparam int CNT_W     = $clog2(WORD_BITS + 2)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      data_lvl,
    input  logic                      clk_rise,
    input  logic                      le_rise,
    input  logic                      le_fall,
    output logic [A_BITS-1:0]         main_swallow,
    output logic [N_BITS-1:0]         main_count,
    output logic [MODE_BITS-1:0]      main_mode,
    output logic [REF_RATIO_BITS-1:0] ref_ratio,
    output logic [FLAG_BITS-1:0]      ref_flags,
    output logic                      main_upd,
    output logic                      ref_upd,
    output logic                      frame_err
);

    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_BITS);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(WORD_BITS + 1);

    load_state_t          state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;
    logic [WORD_BITS-1:0] word_q;
    logic                 accepting, take_word, shift_bit;

    assign accepting = (state_q != ST_LATCH);
    assign take_word = accepting && le_rise;
    assign shift_bit = accepting && clk_rise && !le_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (le_rise)       state_d = ST_LATCH;
                else if (clk_rise) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (le_rise) state_d = ST_LATCH;
            end
            ST_LATCH: begin
                if (le_fall) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            word_q       <= '0;
            main_swallow <= '0;
            main_count   <= '0;
            main_mode    <= '0;
            ref_ratio    <= '0;
            ref_flags    <= '0;
            main_upd     <= 1'b0;
            ref_upd      <= 1'b0;
            frame_err    <= 1'b0;
        end else begin
            main_upd  <= 1'b0;
            ref_upd   <= 1'b0;
            frame_err <= 1'b0;
            if (shift_bit) begin
                word_q <= {word_q[WORD_BITS-2:0], data_lvl};
                if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
            end
            if (take_word) begin
                cnt_q <= '0;
                if (cnt_q != CNT_FULL) begin
                    frame_err <= 1'b1;
                end else if (word_q[0]) begin
                    ref_ratio <= word_q[REF_RATIO_BITS:1];
                    ref_flags <= word_q[WORD_BITS-1:REF_RATIO_BITS+1];
                    ref_upd   <= 1'b1;
                end else begin
                    main_swallow <= word_q[A_BITS:1];
                    main_count   <= word_q[A_BITS+N_BITS:A_BITS+1];
                    main_mode    <= word_q[WORD_BITS-1:A_BITS+N_BITS+1];
                    main_upd     <= 1'b1;
                end
            end else if (state_q == ST_LATCH && le_fall) begin
                cnt_q <= '0;
            end
        end
    end

    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_upd, ref_upd, frame_err}));
    assert_main_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        main_upd |=> !main_upd);
    assert_ref_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ref_upd |=> !ref_upd);
    assert_main_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !main_upd |-> ($stable(main_count) && $stable(main_swallow) && $stable(main_mode)));
    assert_ref_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_upd |-> ($stable(ref_ratio) && $stable(ref_flags)));
    assert_frame_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> $past(le_rise));
    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_OVER);
    assert_latch_ignores_clk_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LATCH && !le_fall) |=> $stable(word_q));

endmodule

// File: rtl/synth_reg_loader.sv
module synth_reg_loader
    import synth_loader_pkg::*;
#(
    parameter int CLK_PERIOD_NS  = 20,
    parameter int MIN_TIME_NS    = 1000,
    parameter int WORD_BITS      = 20,
    parameter int A_BITS         = 7,
    parameter int N_BITS         = 11,
    parameter int REF_RATIO_BITS = 8,
    localparam int MODE_BITS = WORD_BITS - 1 - A_BITS - N_BITS,
    localparam int FLAG_BITS = WORD_BITS - 1 - REF_RATIO_BITS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ser_data,
    input  logic                      ser_clk,
    input  logic                      ser_le,
    output logic [A_BITS-1:0]         main_swallow,
    output logic [N_BITS-1:0]         main_count,
    output logic [MODE_BITS-1:0]      main_mode,
    output logic [REF_RATIO_BITS-1:0] ref_ratio,
    output logic [FLAG_BITS-1:0]      ref_flags,
    output logic                      main_upd,
    output logic                      ref_upd,
    output logic                      frame_err,
    output logic [NUM_FAULTS-1:0]     timing_fault
);

    logic [NUM_PINS-1:0] pin_async, pin_level, pin_rise, pin_fall;

    assign pin_async[PIN_DATA] = ser_data;
    assign pin_async[PIN_CLK]  = ser_clk;
    assign pin_async[PIN_LE]   = ser_le;

    loader_pin_sync #(.NUM_PINS(NUM_PINS)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_async),
        .pin_level (pin_level),
        .pin_rise  (pin_rise),
        .pin_fall  (pin_fall)
    );

    loader_timing_mon #(
        .CLK_PERIOD_NS (CLK_PERIOD_NS),
        .MIN_TIME_NS   (MIN_TIME_NS)
    ) u_timing (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_rise  (pin_rise[PIN_CLK]),
        .clk_fall  (pin_fall[PIN_CLK]),
        .data_edge (pin_rise[PIN_DATA] | pin_fall[PIN_DATA]),
        .le_rise   (pin_rise[PIN_LE]),
        .le_fall   (pin_fall[PIN_LE]),
        .fault     (timing_fault)
    );

    loader_frame_fsm #(
        .WORD_BITS      (WORD_BITS),
        .A_BITS         (A_BITS),
        .N_BITS         (N_BITS),
        .REF_RATIO_BITS (REF_RATIO_BITS)
    ) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .data_lvl     (pin_level[PIN_DATA]),
        .clk_rise     (pin_rise[PIN_CLK]),
        .le_rise      (pin_rise[PIN_LE]),
        .le_fall      (pin_fall[PIN_LE]),
        .main_swallow (main_swallow),
        .main_count   (main_count),
        .main_mode    (main_mode),
        .ref_ratio    (ref_ratio),
        .ref_flags    (ref_flags),
        .main_upd     (main_upd),
        .ref_upd      (ref_upd),
        .frame_err    (frame_err)
    );

endmodule

// File: tb/tb_synth_reg_loader.sv
`timescale 1ns/1ps
module tb_synth_reg_loader;

    localparam int TCLK_NS = 100;
    localparam int PH      = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_data = 1'b0, ser_clk = 1'b0, ser_le = 1'b0;
    logic [6:0]  main_swallow;
    logic [10:0] main_count;
    logic [0:0]  main_mode;
    logic [7:0]  ref_ratio;
    logic [10:0] ref_flags;
    logic        main_upd, ref_upd, frame_err;
    logic [4:0]  timing_fault;

    int n_checks = 0, n_fail = 0;
    int fault_cnt [5];
    logic [1:0]  exp_kind [$];
    logic [19:0] exp_word [$];

    always #(TCLK_NS/2) clk = ~clk;

    synth_reg_loader #(.CLK_PERIOD_NS(TCLK_NS), .MIN_TIME_NS(1000)) dut (
        .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk), .ser_le(ser_le),
        .main_swallow(main_swallow), .main_count(main_count), .main_mode(main_mode),
        .ref_ratio(ref_ratio), .ref_flags(ref_flags), .main_upd(main_upd),
        .ref_upd(ref_upd), .frame_err(frame_err), .timing_fault(timing_fault));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
    endtask

    // scoreboard monitor: kind 0 main, 1 reference, 2 frame error
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < 5; i++) if (timing_fault[i]) fault_cnt[i]++;
            if (main_upd || ref_upd || frame_err) begin
                logic [1:0] got;
                got = main_upd ? 2'd0 : (ref_upd ? 2'd1 : 2'd2);
                if (exp_kind.size() == 0) begin
                    chk(0, "R5", "unexpected strobe kind", got, 3);
                end else begin
                    logic [1:0]  k;
                    logic [19:0] w;
                    k = exp_kind.pop_front();
                    w = exp_word.pop_front();
                    chk(got == k, (k == 2) ? "R6" : "R5", "strobe kind", got, k);
                    if (k == 0 && got == 0) begin
                        chk(main_mode == w[19], "R2", "mode", main_mode, w[19]);
                        chk(main_count == w[18:8], "R2", "program count", main_count, w[18:8]);
                        chk(main_swallow == w[7:1], "R2", "swallow count", main_swallow, w[7:1]);
                    end
                    if (k == 1 && got == 1) begin
                        chk(ref_ratio == w[8:1], "R3", "ratio", ref_ratio, w[8:1]);
                        chk(ref_flags == w[19:9], "R3", "flags", ref_flags, w[19:9]);
                    end
                end
            end
        end
    end

    task automatic shift_bits(input logic [19:0] w, input int nbits, input int first);
        for (int i = 0; i < nbits; i++) begin
            ser_data <= w[first - i];
            cyc(12);
            ser_clk <= 1'b1;
            cyc(PH);
            ser_clk <= 1'b0;
            cyc(3);
        end
    endtask

    task automatic latch_pulse();
        cyc(12);
        ser_le <= 1'b1;
        cyc(PH);
        ser_le <= 1'b0;
        cyc(PH);
    endtask

    task automatic send_word(input logic [19:0] w);
        exp_kind.push_back(w[0] ? 2'd1 : 2'd0);
        exp_word.push_back(w);
        shift_bits(w, 20, 19);
        latch_pulse();
    endtask

    function automatic int fault_total();
        int s = 0;
        for (int i = 0; i < 5; i++) s += fault_cnt[i];
        return s;
    endfunction

    task automatic expect_fault(input int idx, input string req, input int base [5]);
        cyc(10);
        for (int i = 0; i < 5; i++)
            chk((fault_cnt[i] - base[i]) == ((i == idx) ? 1 : 0), req, "fault pulse count",
                fault_cnt[i] - base[i], (i == idx) ? 1 : 0);
    endtask

    initial begin
        int base [5];
        logic [19:0] w;
        for (int i = 0; i < 5; i++) fault_cnt[i] = 0;
        cyc(4);
        // R7: reset state
        chk({main_swallow, main_count, main_mode, ref_ratio, ref_flags} == '0, "R7",
            "registers after reset", {main_count, main_swallow}, 0);
        chk({main_upd, ref_upd, frame_err, timing_fault} == '0, "R7", "strobes after reset",
            {main_upd, ref_upd, frame_err, timing_fault}, 0);
        rst_n <= 1'b1;
        cyc(5);

        // R1 R2: main word, mode 1, N=63, A=12
        send_word({1'b1, 11'd63, 7'd12, 1'b0});
        // R1 R3: reference word, ratio 160, flags 0x5A3
        send_word({11'h5A3, 8'd160, 1'b1});
        // R2: all-ones fields
        send_word({1'b0, 11'd2047, 7'd127, 1'b0});
        // R3: ratio 255, flags zero
        send_word({11'd0, 8'd255, 1'b1});
        chk(fault_total() == 0, "R8", "faults on clean traffic", fault_total(), 0);

        // R6: 19 bits then latch -> discarded
        exp_kind.push_back(2'd2); exp_word.push_back('0);
        shift_bits(20'hABCDE, 19, 19);
        latch_pulse();
        chk(main_count == 11'd2047 && ref_ratio == 8'd255, "R6", "outputs after short frame",
            {main_count, ref_ratio}, {11'd2047, 8'd255});
        // R6: 21 bits then latch -> discarded
        exp_kind.push_back(2'd2); exp_word.push_back('0);
        shift_bits(20'h12345, 20, 19);
        shift_bits(20'h1, 1, 0);
        latch_pulse();
        chk(main_swallow == 7'd127 && ref_flags == 11'd0, "R6", "outputs after long frame",
            {main_swallow, ref_flags}, {7'd127, 11'd0});

        // R4: full word shifted without latch leaves outputs unchanged
        w = {1'b1, 11'd300, 7'd5, 1'b0};
        shift_bits(w, 20, 19);
        cyc(20);
        chk(main_count == 11'd2047 && main_swallow == 7'd127 && main_mode == 1'b0, "R4",
            "outputs before latch", {main_mode, main_count, main_swallow}, {1'b0, 11'd2047, 7'd127});
        exp_kind.push_back(2'd0); exp_word.push_back(w);
        latch_pulse();
        chk(main_count == 11'd300, "R4", "program count after latch", main_count, 300);

        // R13: clock during latch ignored; new word counted from zero
        exp_kind.push_back(2'd2); exp_word.push_back('0);
        cyc(12);
        ser_le <= 1'b1;
        cyc(12); ser_clk <= 1'b1; cyc(12); ser_clk <= 1'b0; cyc(12);
        ser_le <= 1'b0;
        cyc(PH);
        send_word({11'h7FF, 8'h3C, 1'b1});
        chk(ref_ratio == 8'h3C, "R13", "ratio after ignored clock", ref_ratio, 8'h3C);

        // R8: short clock high phase
        base = fault_cnt;
        cyc(20); ser_clk <= 1'b1; cyc(4); ser_clk <= 1'b0; cyc(20);
        expect_fault(0, "R8", base);
        // R9: data change 4 cycles before clock rise
        base = fault_cnt;
        ser_data <= ~ser_data; cyc(4); ser_clk <= 1'b1; cyc(PH); ser_clk <= 1'b0; cyc(20);
        expect_fault(1, "R9", base);
        // R10: data change 4 cycles after clock rise
        base = fault_cnt;
        ser_clk <= 1'b1; cyc(4); ser_data <= ~ser_data; cyc(11); ser_clk <= 1'b0; cyc(20);
        expect_fault(2, "R10", base);
        // R11: latch rises 5 cycles after clock rise (count 4 -> frame error too)
        base = fault_cnt;
        exp_kind.push_back(2'd2); exp_word.push_back('0);
        ser_clk <= 1'b1; cyc(5); ser_le <= 1'b1; cyc(10); ser_clk <= 1'b0; cyc(5);
        ser_le <= 1'b0; cyc(20);
        expect_fault(3, "R11", base);
        // R12: latch high for 4 cycles (count 0 -> frame error too)
        base = fault_cnt;
        exp_kind.push_back(2'd2); exp_word.push_back('0);
        ser_le <= 1'b1; cyc(4); ser_le <= 1'b0; cyc(20);
        expect_fault(4, "R12", base);

        // recovery: clean word after violations
        send_word({1'b0, 11'd64, 7'd1, 1'b0});
        cyc(20);
        chk(exp_kind.size() == 0, "R5", "scoreboard items left", exp_kind.size(), 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(TCLK_NS * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule